// File: doc/BRIEF.md
# Divided Clock Generator with Undivided Bypass Bank

This block takes one input clock and drives two output banks from it. The bypass bank is a straight copy of the input, at its own frequency. The divided bank carries the input divided by 2, 4, 8 or 16, as chosen by a 2-bit ratio code. The divided bank drives two outputs that are always identical. Every output also has a complement.

The input clock `src_clk` is treated as a level signal and sampled by the fabric clock `clk`. Both banks leave through one register stage clocked by `clk`. A rising input edge therefore reaches the bypass bank and the divided bank on the same `clk` cycle, whatever the ratio. The divided bank uses bit 0, 1, 2 or 3 of a counter that advances on input rising edges, so every ratio has a 50% duty cycle.

The active-low `rst_n` input works synchronously. While it is low, the divided bank is held low and its counter is cleared, but the bypass bank keeps running. A new ratio code is taken only at the end of a complete divided period, which is the point where the divided output falls. It is also taken while reset is held. This rule prevents short pulses when the ratio changes.

Top module: `clk_div_bypass`

## Requirements
- R1: The ratio code `sel` gives the divided-bank frequency as the input frequency divided by 2^(sel+1): code 0 divides by 2, 1 by 4, 2 by 8, 3 by 16. Bit 0 is the least significant bit.
- R2: `qa` equals `src_clk` as sampled at the previous `clk` edge, whatever `sel` and `rst_n` are. `qa_n` is always the inverse of `qa`.
- R3: A `clk` edge that samples `rst_n` low forces every `qb` bit to 0 and every `qb_n` bit to 1. These values stay while `rst_n` remains low.
- R4: All bits of `qb` are equal at every cycle, and `qb_n` is the bitwise inverse of `qb`.
- R5: A change on `qb` outside reset happens only on the cycle where `qa` rises. A rising edge of `qb` and a rising edge of `qa` appear in the same cycle.
- R6: Outside a ratio change, each high time and each low time of `qb` lasts exactly 2^sel input clock periods (50% duty cycle).
- R7: After `rst_n` goes high, the first rising edge of `qb` comes together with the 2^sel-th rising edge of `qa`, counted from the release.
- R8: A change of `sel` in mid-period does not take effect until the current divided period completes, at a falling edge of `qb`. Every high or low time of `qb` therefore equals the half-period of either the old ratio or the new ratio.
- R9: A ratio code presented while `rst_n` is low is the one in force from release, as R7 describes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock that samples the input clock and clocks every register |
| rst_n | input | 1 | Active-low synchronous hold of the divided bank |
| src_clk | input | 1 | Input clock, sampled as a level |
| sel | input | SEL_W (2) | Division ratio code |
| qa | output | 1 | Bypass bank: undivided copy of the input |
| qa_n | output | 1 | Complement of `qa` |
| qb | output | NUM_B (2) | Divided bank outputs, all identical |
| qb_n | output | NUM_B (2) | Complements of `qb` |

## Verification
A wrong counter value or a wrong ratio selection shows up as a `qb` high or low time of the wrong length within one divided period, at most 16 input periods. A counter that is not cleared, or a reset that does not hold, moves the first `qb` rising edge away from the 2^sel-th input edge after release. Applying a ratio at the wrong moment leaves a run of `qb` that matches neither the old nor the new half-period, at the change itself. A path mismatch between the banks puts a `qb` edge on a cycle where `qa` did not rise, which is visible at that cycle.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  // Ratio codes; numeric value equals log2(ratio) - 1.
  typedef enum logic [1:0] {
    RATIO_2  = 2'd0,
    RATIO_4  = 2'd1,
    RATIO_8  = 2'd2,
    RATIO_16 = 2'd3
  } ratio_e;
endpackage

// File: rtl/clkdiv_edge_det.sv
module clkdiv_edge_det (
  input  logic clk,
  input  logic src_clk,
  output logic rise
);
  logic src_prev;

  always_ff @(posedge clk) begin
    src_prev <= src_clk;
  end

  assign rise = src_clk & ~src_prev;
endmodule

// File: rtl/clkdiv_ratio_ctrl.sv
module clkdiv_ratio_ctrl #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_in,
  input  logic             period_end,
  output logic [SEL_W-1:0] sel_cur
);
  // The ratio in force changes only at a period boundary or while held.
  always_ff @(posedge clk) begin
    if (!rst_n || period_end) begin
      sel_cur <= sel_in;
    end
  end
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
  parameter int CNT_W = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic [SEL_W-1:0] sel_cur,
  output logic             period_end,
  output logic             b_next
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nx;
  logic [CNT_W-1:0] span;

  always_comb begin
    span       = {CNT_W{1'b1}} >> (CNT_W - 1 - int'(sel_cur));
    period_end = rise && ((cnt & span) == span);
    if (!rst_n || period_end) begin
      cnt_nx = '0;
    end else if (rise) begin
      cnt_nx = cnt + 1'b1;
    end else begin
      cnt_nx = cnt;
    end
    b_next = cnt_nx[sel_cur];
  end

  always_ff @(posedge clk) begin
    cnt <= cnt_nx;
  end
endmodule

// File: rtl/clkdiv_out_stage.sv
module clkdiv_out_stage #(
  parameter int NUM_B = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_clk,
  input  logic             b_next,
  output logic             qa,
  output logic             qa_n,
  output logic [NUM_B-1:0] qb,
  output logic [NUM_B-1:0] qb_n
);
  logic qa_r;

  // Bypass register: same depth as the divided-bank registers, never held.
  always_ff @(posedge clk) begin
    qa_r <= src_clk;
  end

  assign qa   = qa_r;
  assign qa_n = ~qa_r;

  // One register per divided output so each drives its own load.
  for (genvar g = 0; g < NUM_B; g++) begin : g_bank_b
    logic qb_r;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        qb_r <= 1'b0;
      end else begin
        qb_r <= b_next;
      end
    end
    assign qb[g]   = qb_r;
    assign qb_n[g] = ~qb_r;
  end
endmodule

// File: rtl/clk_div_bypass.sv
module clk_div_bypass #(
  parameter int CNT_W = 4,
  parameter int NUM_B = 2,
  localparam int SEL_W = $clog2(CNT_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_clk,
  input  logic [SEL_W-1:0] sel,
  output logic             qa,
  output logic             qa_n,
  output logic [NUM_B-1:0] qb,
  output logic [NUM_B-1:0] qb_n
);
  logic             rise;
  logic             period_end;
  logic             b_next;
  logic [SEL_W-1:0] sel_cur;

  clkdiv_edge_det u_edge (
    .clk     (clk),
    .src_clk (src_clk),
    .rise    (rise)
  );

  clkdiv_ratio_ctrl #(.SEL_W(SEL_W)) u_ratio (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_in     (sel),
    .period_end (period_end),
    .sel_cur    (sel_cur)
  );

  clkdiv_counter #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise       (rise),
    .sel_cur    (sel_cur),
    .period_end (period_end),
    .b_next     (b_next)
  );

  clkdiv_out_stage #(.NUM_B(NUM_B)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_clk (src_clk),
    .b_next  (b_next),
    .qa      (qa),
    .qa_n    (qa_n),
    .qb      (qb),
    .qb_n    (qb_n)
  );
endmodule

// File: rtl/clk_div_bypass_chk.sv
module clk_div_bypass_chk #(
  parameter int NUM_B = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             src_clk,
  input logic             qa,
  input logic             qa_n,
  input logic [NUM_B-1:0] qb,
  input logic [NUM_B-1:0] qb_n
);
  logic [1:0] age = 2'b00;
  logic       armed;

  always_ff @(posedge clk) begin
    age <= {age[0], 1'b1};
  end
  assign armed = age[1];

  // R3: a sampled low reset forces the divided bank low on the next cycle
  a_r3_hold_low: assert property (@(posedge clk) disable iff (!armed)
    !rst_n |=> (qb == '0 && qb_n == '1));

  // R2: bypass is the input delayed by one register, with a true complement
  a_r2_bypass_copy: assert property (@(posedge clk) disable iff (!armed)
    (qa == $past(src_clk)) && (qa_n == ~qa));

  // R4: divided outputs identical, complements inverted
  a_r4_twins: assert property (@(posedge clk) disable iff (!armed)
    (qb == {NUM_B{qb[0]}}) && (qb_n == ~qb));

  // R5: outside reset the divided bank moves only with a bypass rising edge
  a_r5_align: assert property (@(posedge clk) disable iff (!armed)
    (rst_n && $past(rst_n) && !$stable(qb[0])) |-> $rose(qa));
endmodule

bind clk_div_bypass clk_div_bypass_chk #(.NUM_B(NUM_B)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .src_clk (src_clk),
  .qa      (qa),
  .qa_n    (qa_n),
  .qb      (qb),
  .qb_n    (qb_n)
);

// File: tb/tb_clk_div_bypass.sv
module tb_clk_div_bypass;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_B      = 2;
  localparam int LIMIT      = 4000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             src_clk = 1'b0;
  logic [1:0]       sel = 2'd3;
  logic             qa, qa_n;
  logic [NUM_B-1:0] qb, qb_n;

  int checks = 0;
  int failures = 0;
  int half_len = 2;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  clk_div_bypass #(.CNT_W(4), .NUM_B(NUM_B)) dut (
    .clk(clk), .rst_n(rst_n), .src_clk(src_clk), .sel(sel),
    .qa(qa), .qa_n(qa_n), .qb(qb), .qb_n(qb_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Input clock generator: toggles every half_len fabric cycles.
  initial begin
    forever begin
      repeat (half_len) @(negedge clk);
      src_clk = ~src_clk;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Sample point: a quarter period after the rising edge.
  task automatic tick();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  function automatic int half_run(input int code, input int hl);
    return (1 << code) * 2 * hl;  // 2^code input periods, in fabric cycles
  endfunction

  // Continuous port checks.
  logic last_qa_m = 1'b0;
  logic last_qb_m = 1'b0;
  initial begin
    forever begin
      tick();
      if (mon_on) begin
        check(qa == src_clk && qa_n == ~qa, "R2 bypass copy", int'(qa), int'(src_clk));
        check(qb == {NUM_B{qb[0]}} && qb_n == ~qb, "R4 twin outputs", int'(qb), int'({NUM_B{qb[0]}}));
        if (qb[0] && !last_qb_m)
          check(qa && !last_qa_m, "R5 edge alignment", int'(qa), 1);
      end
      last_qa_m = qa;
      last_qb_m = qb[0];
    end
  end

  task automatic hold_reset(input logic [1:0] code, input int cycles);
    @(negedge clk);
    rst_n = 1'b0;
    sel   = code;
    repeat (cycles) tick();
  endtask

  // Release reset and count bypass rising edges until the first divided rise.
  task automatic release_and_count(input logic [1:0] code, input string req);
    int   cnt = 0;
    int   guard = 0;
    logic lqa;
    @(negedge clk);
    rst_n = 1'b1;
    lqa = qa;
    do begin
      tick();
      guard++;
      if (qa && !lqa) cnt++;
      lqa = qa;
    end while (!qb[0] && guard < LIMIT);
    check(cnt == (1 << code), req, cnt, 1 << code);
  endtask

  // Measure n complete high/low runs of qb; each must be exp_a or exp_b.
  task automatic measure(input int n, input int exp_a, input int exp_b, input string req);
    logic last;
    int   guard = 0;
    last = qb[0];
    do begin tick(); guard++; end while (qb[0] == last && guard < LIMIT);
    for (int i = 0; i < n; i++) begin
      int len = 0;
      last = qb[0];
      do begin tick(); len++; end while (qb[0] == last && len < LIMIT);
      check(len == exp_a || len == exp_b, req, len, exp_a);
    end
  endtask

  initial begin
    void'($urandom(32'd1729));
    // Reset state: divided bank held, bypass still running (R3, R2).
    half_len = 2;
    hold_reset(2'd3, 3);
    mon_on = 1'b1;
    begin
      int toggles = 0;
      logic lqa = qa;
      for (int i = 0; i < 24; i++) begin
        tick();
        check(qb == '0 && qb_n == '1, "R3 hold during reset", int'(qb), 0);
        if (qa != lqa) toggles++;
        lqa = qa;
      end
      check(toggles >= 4, "R2 bypass runs in reset", toggles, 4);
    end

    // Directed: every ratio code, fastest input (R1, R6, R7).
    half_len = 1;
    for (int c = 0; c < 4; c++) begin
      hold_reset(2'(c), 4);
      release_and_count(2'(c), "R7 first rise after release");
      measure(4, half_run(c, 1), half_run(c, 1), "R1 R6 half period");
    end

    // Random ratio codes and input periods.
    for (int t = 0; t < 8; t++) begin
      int c = int'($urandom_range(3, 0));
      hold_reset(2'd0, 2);
      half_len = int'($urandom_range(3, 1));
      hold_reset(2'(c), 4);
      release_and_count(2'(c), "R7 random release");
      measure(3, half_run(c, half_len), half_run(c, half_len), "R1 R6 random ratio");
    end

    // Ratio change mid-run, both directions (R8).
    half_len = 1;
    hold_reset(2'd0, 3);
    @(negedge clk); rst_n = 1'b1;
    repeat (9) tick();
    @(negedge clk); sel = 2'd3;
    measure(3, half_run(0, 1), half_run(3, 1), "R8 change 2 to 16");
    measure(2, half_run(3, 1), half_run(3, 1), "R8 new ratio 16 in force");
    repeat (5) tick();
    @(negedge clk); sel = 2'd1;
    measure(3, half_run(3, 1), half_run(1, 1), "R8 change 16 to 4");
    measure(2, half_run(1, 1), half_run(1, 1), "R8 new ratio 4 in force");

    // Reset asserted while running: hold from the next edge (R3).
    repeat (3) tick();
    @(negedge clk); rst_n = 1'b0;
    tick();
    check(qb == '0 && qb_n == '1, "R3 hold one cycle after assert", int'(qb), 0);

    // Code changed only while held is the one used at release (R9).
    @(negedge clk); sel = 2'd0;
    repeat (3) tick();
    @(negedge clk); sel = 2'd2;
    repeat (3) tick();
    release_and_count(2'd2, "R9 code loaded in reset");
    measure(2, half_run(2, 1), half_run(2, 1), "R9 ratio after release");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule